// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block sits beside a set of processor cores that share coherent memory and decides whether each core's store-exclusive may complete. Every core owns one reservation slot, which is either open or armed with a granule number (the request address with its low `GRANULE_LOG2` bits dropped). A load-exclusive arms the slot. A store-exclusive completes only if its own slot is still armed on the same granule, the core's private monitor agrees, and the store wins the single memory write port.

Any write that reaches memory disarms every slot armed on the written granule. That write may be a passing store-exclusive or a plain store. So when two cores race for one lock word, only the first of them completes, and reservations on other granules are not touched. Each store-exclusive gets a pass/fail response one cycle after it is issued. Writes leave through one registered memory port in the same cycle as the response.

Top module: `xmon_global_hub`

## Requirements
- R1: After reset every slot is open, `mem_we` and all response valids are low, and a store-exclusive issued before any load-exclusive fails.
- R2: A load-exclusive arms the core's slot with the address's granule (`addr >> GRANULE_LOG2`). A later store-exclusive to any byte in that granule passes.
- R3: A passing store-exclusive raises `stx_rsp_vld` with `stx_rsp_fail`=0 one cycle later. In that same cycle `mem_we` is 1 and `mem_addr`/`mem_wdata` carry its address and data. Its slot is then open, so an immediate repeat fails.
- R4: A store-exclusive whose slot is open, or armed on a different granule, responds with `stx_rsp_fail`=1 and produces no write.
- R5: A store-exclusive issued with `local_fail` high fails with status 1 and produces no write, even when the slot is armed on a matching granule.
- R6: A passing store-exclusive disarms every other core's slot on the same granule, so their subsequent store-exclusives fail.
- R7: Slots armed on different granules are independent: two cores each complete their store-exclusive in turn.
- R8: A plain store from any core is written to memory one cycle later and disarms every slot armed on its granule.
- R9: The write port goes first to the lowest-index plain store, and otherwise to the lowest-index eligible store-exclusive. Any store-exclusive that is not granted fails. When several cores store-exclusive to one granule together, only the lowest index passes.
- R10: A clear request opens only the issuing core's slot.
- R11: After a failure, a core that repeats the load-exclusive and then the store-exclusive, with no conflicting write in between, passes.
- R12: A load-exclusive issued in the same cycle as a granted write from another core to the same granule leaves the slot open. A write to a different granule in that cycle does not prevent the slot from arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_req | input | NUM_CORES | Per-core load-exclusive request |
| stx_req | input | NUM_CORES | Per-core store-exclusive request |
| st_req | input | NUM_CORES | Per-core plain store request |
| clr_req | input | NUM_CORES | Per-core reservation clear |
| req_addr | input | NUM_CORES*ADDR_W | Per-core request address, core k in bits [k*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_CORES*DATA_W | Per-core store data, core k in bits [k*DATA_W +: DATA_W] |
| local_fail | input | NUM_CORES | Private monitor verdict for this cycle's store-exclusive, 1 = fail |
| stx_rsp_vld | output | NUM_CORES | Store-exclusive response valid, one cycle after the request |
| stx_rsp_fail | output | NUM_CORES | Response status: 0 pass, 1 fail |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The bench targets the races.

- **Two cores reserve one granule.** Only the first store may pass. A design that skips cross-core disarming would let both complete, and both would then believe they hold the lock.
- **Three cores store-exclusive to one granule in the same cycle.** This checks the priority rule. A wrong arbiter would either pass several cores or drop the write entirely.
- **A plain store beats a competing store-exclusive.** A plain store disarms a watcher on its granule while leaving a reservation elsewhere alone.
- **A load-exclusive lands in the same cycle as another core's write to that granule.** A design that lets the new reservation survive would hand out a stale lock.
- **The granule boundary.** Addresses inside and just outside one granule catch comparisons made on the wrong bits.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

   // One core's request for one cycle; at most one field is set.
   typedef struct packed {
      logic ldx;
      logic stx;
      logic st;
      logic clr;
   } xmon_op_t;

endpackage

// File: rtl/xmon_slot.sv
module xmon_slot
   import xmon_pkg::*;
#(
   parameter int GRAN_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xmon_op_t          op,
   input  logic [GRAN_W-1:0] req_gran,
   input  logic              kill_vld,
   input  logic [GRAN_W-1:0] kill_gran,
   output logic              hit
);

   logic              armed_q;
   logic [GRAN_W-1:0] gran_q;
   logic              armed_d;
   logic [GRAN_W-1:0] gran_d;

   always_comb begin
      armed_d = armed_q;
      gran_d  = gran_q;
      if (op.ldx) begin
         armed_d = 1'b1;
         gran_d  = req_gran;
      end else if (op.stx || op.clr) begin
         armed_d = 1'b0;
      end
      // a granted write to the reserved granule wins over everything
      if (kill_vld && armed_d && (gran_d == kill_gran)) begin
         armed_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         gran_q  <= '0;
      end else begin
         armed_q <= armed_d;
         gran_q  <= gran_d;
      end
   end

   assign hit = armed_q && (gran_q == req_gran);

   AST_CLEAR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      op.clr |=> !armed_q); // R10

   AST_LDX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (op.ldx && !(kill_vld && kill_gran == req_gran))
      |=> (armed_q && gran_q == $past(req_gran))); // R2

   AST_KILL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_vld && armed_q && gran_q == kill_gran && !op.ldx) |=> !armed_q); // R6

endmodule

// File: rtl/xmon_wr_arb.sv
module xmon_wr_arb #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] plain_req,
   input  logic [NUM_CORES-1:0] excl_req,
   output logic [NUM_CORES-1:0] grant
);

   logic found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (!found && plain_req[i]) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
      for (int i = 0; i < NUM_CORES; i++) begin
         if (!found && excl_req[i]) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9

   AST_PLAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (|plain_req) |-> (|(grant & plain_req))); // R9

   AST_NO_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(plain_req | excl_req)) |-> (|grant)); // R9

endmodule

// File: rtl/xmon_global_hub.sv
module xmon_global_hub
   import xmon_pkg::*;
#(
   parameter int NUM_CORES    = 4,
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int GRANULE_LOG2 = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES-1:0]        ldx_req,
   input  logic [NUM_CORES-1:0]        stx_req,
   input  logic [NUM_CORES-1:0]        st_req,
   input  logic [NUM_CORES-1:0]        clr_req,
   input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
   input  logic [NUM_CORES*DATA_W-1:0] req_wdata,
   input  logic [NUM_CORES-1:0]        local_fail,
   output logic [NUM_CORES-1:0]        stx_rsp_vld,
   output logic [NUM_CORES-1:0]        stx_rsp_fail,
   output logic                        mem_we,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_wdata
);

   localparam int GRAN_W = ADDR_W - GRANULE_LOG2;

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("xmon_global_hub: NUM_CORES must be at least 1");
   end
   if (GRANULE_LOG2 < 0 || GRANULE_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("xmon_global_hub: GRANULE_LOG2 must lie in [0, ADDR_W)");
   end

   logic [NUM_CORES-1:0] hit;
   logic [NUM_CORES-1:0] excl_ok;
   logic [NUM_CORES-1:0] grant;
   logic [ADDR_W-1:0]    win_addr;
   logic [DATA_W-1:0]    win_data;
   logic                 wr_fire;
   logic [GRAN_W-1:0]    kill_gran;

   assign kill_gran = win_addr[ADDR_W-1:GRANULE_LOG2];

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      xmon_op_t          op;
      logic [GRAN_W-1:0] gran;

      assign op.ldx = ldx_req[g];
      assign op.stx = stx_req[g];
      assign op.st  = st_req[g];
      assign op.clr = clr_req[g];
      assign gran   = req_addr[g*ADDR_W+GRANULE_LOG2 +: GRAN_W];

      xmon_slot #(.GRAN_W(GRAN_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .op        (op),
         .req_gran  (gran),
         .kill_vld  (wr_fire),
         .kill_gran (kill_gran),
         .hit       (hit[g])
      );

      assign excl_ok[g] = stx_req[g] & hit[g] & ~local_fail[g];

      AST_LOCAL_VETO: assert property (@(posedge clk) disable iff (!rst_n)
         (stx_req[g] && local_fail[g]) |=> stx_rsp_fail[g]); // R5

      AST_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
         (stx_req[g] && !hit[g]) |=> (stx_rsp_vld[g] && stx_rsp_fail[g])); // R4

      AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
         (stx_rsp_vld[g] && !stx_rsp_fail[g])
         |-> (mem_we && mem_addr == $past(req_addr[g*ADDR_W +: ADDR_W]))); // R3
   end

   xmon_wr_arb #(.NUM_CORES(NUM_CORES)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .plain_req (st_req),
      .excl_req  (excl_ok),
      .grant     (grant)
   );

   always_comb begin
      win_addr = '0;
      win_data = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (grant[i]) begin
            win_addr = win_addr | req_addr[i*ADDR_W +: ADDR_W];
            win_data = win_data | req_wdata[i*DATA_W +: DATA_W];
         end
      end
   end

   assign wr_fire = |grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stx_rsp_vld  <= '0;
         stx_rsp_fail <= '0;
         mem_we       <= 1'b0;
         mem_addr     <= '0;
         mem_wdata    <= '0;
      end else begin
         stx_rsp_vld  <= stx_req;
         stx_rsp_fail <= stx_req & ~grant;
         mem_we       <= wr_fire;
         mem_addr     <= win_addr;
         mem_wdata    <= win_data;
      end
   end

   AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stx_rsp_vld & ~stx_rsp_fail) <= 1); // R9

endmodule

// File: tb/xmon_global_hub_test.sv
module xmon_global_hub_test;

   localparam int N  = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int GL = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    ldx_req = '0;
   logic [N-1:0]    stx_req = '0;
   logic [N-1:0]    st_req = '0;
   logic [N-1:0]    clr_req = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N-1:0]    local_fail = '0;
   logic [N-1:0]    stx_rsp_vld;
   logic [N-1:0]    stx_rsp_fail;
   logic            mem_we;
   logic [AW-1:0]   mem_addr;
   logic [DW-1:0]   mem_wdata;

   always #5 clk = ~clk;

   xmon_global_hub #(.NUM_CORES(N), .ADDR_W(AW), .DATA_W(DW), .GRANULE_LOG2(GL)) uut (
      .clk(clk), .rst_n(rst_n), .ldx_req(ldx_req), .stx_req(stx_req), .st_req(st_req),
      .clr_req(clr_req), .req_addr(req_addr), .req_wdata(req_wdata), .local_fail(local_fail),
      .stx_rsp_vld(stx_rsp_vld), .stx_rsp_fail(stx_rsp_fail), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   typedef struct {
      logic [N-1:0]  vld;
      logic [N-1:0]  fail;
      logic          we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         tag;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   exp_t got;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   task automatic clear_cur();
      cur.vld = '0; cur.fail = '0; cur.we = 1'b0; cur.a = '0; cur.d = '0; cur.tag = "";
   endtask

   task automatic ldx(int c, logic [AW-1:0] a);
      ldx_req[c] = 1'b1;
      req_addr[c*AW +: AW] = a;
   endtask

   task automatic clr(int c);
      clr_req[c] = 1'b1;
   endtask

   task automatic stx(int c, logic [AW-1:0] a, logic [DW-1:0] d, bit pass, bit lf = 1'b0);
      stx_req[c] = 1'b1;
      req_addr[c*AW +: AW] = a;
      req_wdata[c*DW +: DW] = d;
      local_fail[c] = lf;
      cur.vld[c] = 1'b1;
      cur.fail[c] = !pass;
      if (pass) begin
         cur.we = 1'b1; cur.a = a; cur.d = d;
      end
   endtask

   task automatic st(int c, logic [AW-1:0] a, logic [DW-1:0] d);
      st_req[c] = 1'b1;
      req_addr[c*AW +: AW] = a;
      req_wdata[c*DW +: DW] = d;
      cur.we = 1'b1; cur.a = a; cur.d = d;
   endtask

   // Driver: the inputs set so far are sampled at the next edge; the expectation is queued.
   task automatic go(string tag);
      cur.tag = tag;
      @(posedge clk);
      #1;
      q.push_back(cur);
      ldx_req = '0; stx_req = '0; st_req = '0; clr_req = '0; local_fail = '0;
      clear_cur();
   endtask

   // Monitor: the registered outputs of the edge just passed are compared at the falling edge.
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         got = q.pop_front();
         checks++;
         if (stx_rsp_vld !== got.vld || (stx_rsp_fail & got.vld) !== got.fail) begin
            errors++;
            $display("FAIL %s response: vld=%b fail=%b expected vld=%b fail=%b",
                     got.tag, stx_rsp_vld, stx_rsp_fail, got.vld, got.fail);
         end
         checks++;
         if (mem_we !== got.we || (got.we && (mem_addr !== got.a || mem_wdata !== got.d))) begin
            errors++;
            $display("FAIL %s write: we=%b addr=%h data=%h expected we=%b addr=%h data=%h",
                     got.tag, mem_we, mem_addr, mem_wdata, got.we, got.a, got.d);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clear_cur();
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (mem_we !== 1'b0 || stx_rsp_vld !== '0) begin
         errors++;
         $display("FAIL R1 reset outputs: we=%b vld=%b expected we=0 vld=0", mem_we, stx_rsp_vld);
      end
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      // R1: nothing reserved right after reset
      stx(3, 32'h0, 32'h11, 1'b0);
      go("R1");
      // R2/R3: a reservation covers the whole 64-byte granule; the slot opens after use
      ldx(0, 32'h100);
      go("R2");
      stx(0, 32'h13C, 32'hAA, 1'b1);
      go("R2");
      stx(0, 32'h100, 32'hAB, 1'b0);
      go("R3");
      // R4: a neighbouring granule does not match
      ldx(1, 32'h200);
      go("R4");
      stx(1, 32'h240, 32'hBB, 1'b0);
      go("R4");
      // R5: the private monitor vetoes
      ldx(2, 32'h300);
      go("R5");
      stx(2, 32'h300, 32'hCC, 1'b0, 1'b1);
      go("R5");
      // R6/R11: two cores on one lock; the loser retries
      ldx(0, 32'h400);
      ldx(1, 32'h410);
      go("R6");
      stx(0, 32'h400, 32'h1, 1'b1);
      go("R6");
      stx(1, 32'h410, 32'h1, 1'b0);
      go("R6");
      ldx(1, 32'h410);
      go("R11");
      stx(1, 32'h410, 32'h2, 1'b1);
      go("R11");
      // R7: distinct granules stay independent
      ldx(0, 32'h500);
      ldx(1, 32'h600);
      go("R7");
      stx(0, 32'h500, 32'h5, 1'b1);
      go("R7");
      stx(1, 32'h600, 32'h6, 1'b1);
      go("R7");
      // R8: a plain store kills a matching reservation only
      ldx(2, 32'h700);
      ldx(3, 32'h1000);
      go("R8");
      st(0, 32'h720, 32'h55);
      go("R8");
      stx(2, 32'h700, 32'h7, 1'b0);
      stx(3, 32'h1000, 32'h8, 1'b1);
      go("R8");
      // R9: same-cycle race, lowest index wins
      ldx(1, 32'h800);
      ldx(2, 32'h800);
      ldx(3, 32'h804);
      go("R9");
      stx(1, 32'h800, 32'h91, 1'b1);
      stx(2, 32'h800, 32'h92, 1'b0);
      stx(3, 32'h804, 32'h93, 1'b0);
      go("R9");
      // R9: a plain store takes the port ahead of a store-exclusive
      ldx(0, 32'h900);
      go("R9");
      stx(0, 32'h900, 32'h94, 1'b0);
      st(2, 32'hA00, 32'h95);
      go("R9");
      // R10: clear affects only its own core
      ldx(0, 32'hB00);
      ldx(1, 32'hC00);
      go("R10");
      clr(0);
      go("R10");
      stx(1, 32'hC00, 32'hA1, 1'b1);
      go("R10");
      stx(0, 32'hB00, 32'hA2, 1'b0);
      go("R10");
      // R12: a load-exclusive racing a write to its granule ends open
      ldx(0, 32'hD00);
      go("R12");
      stx(0, 32'hD00, 32'hC1, 1'b1);
      ldx(1, 32'hD08);
      go("R12");
      stx(1, 32'hD08, 32'hC2, 1'b0);
      go("R12");
      // R12: a write elsewhere in the same cycle leaves the new reservation intact
      ldx(1, 32'hE00);
      st(2, 32'hF00, 32'hC3);
      go("R12");
      stx(1, 32'hE00, 32'hC4, 1'b1);
      go("R12");
      @(negedge clk);
      #1;
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard drain: actual=%0d pending expected=0", q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule